// File: doc/BRIEF.md
# ULPI PHY-Side Register Bank

This block holds the register storage of one emulated ULPI transceiver port, as seen from the link. A link-side command parser, which sits outside this block, decodes register commands from the bus and presents each one as a single-cycle request. The request carries an address, write data, a read/write flag and a flag that marks an extended-mode access. For reads the block answers with registered data one cycle later. The bus handshaking itself is not part of this block, and neither is the system interconnect.

Two addressing methods are supported. Immediate accesses use a 6-bit address. Extended accesses use an 8-bit address, and the immediate space is mirrored into the lowest 64 bytes of the extended space. The address 0x2F is reserved as the escape the parser uses to enter extended mode, so it never names a register. Each control register can be reached at three addresses: a base address that overwrites it, a set alias that ORs data into it, and a clear alias that removes the bits given in the data. One event-latch register collects external event pulses and is emptied when it is read.

The register map is as follows. Identification bytes sit at 0x00 to 0x03. The control registers sit at bases 0x04, 0x07, 0x0A and 0x16, with reset values 0x41, 0x00, 0x06 and 0x00. The event latch sits at 0x14.

Top module: `ulpi_phy_regbank`

## Requirements
- R1: While `rst` is high at a rising edge (synchronous, active high), the four control registers load their reset values. These are 0x41 at base 0x04, 0x00 at base 0x07, 0x06 at base 0x0A and 0x00 at base 0x16. The event latch loads 0x00, and `rd_valid`, `rd_data` and `err_imm_escape` load 0.
- R2: A read request accepted at a rising edge (`req_valid`=1, `req_write`=0) raises `rd_valid` for exactly the following cycle, with the read value on `rd_data`. In every cycle where `rd_valid` is 0, `rd_data` is 0x00.
- R3: Addresses 0x00, 0x01, 0x02 and 0x03 read, in that order, the low and high bytes of parameter `VENDOR_ID` and then the low and high bytes of parameter `PRODUCT_ID`. Writes to these addresses change nothing.
- R4: A write to the base address of a control register replaces its value with the write data.
- R5: A write to base+1 of a control register ORs the write data into its value.
- R6: A write to base+2 of a control register clears every bit that is 1 in the write data and keeps the other bits.
- R7: A read from base, base+1 or base+2 of a control register returns its current value. The read does not change that value.
- R8: An immediate access (`req_ext`=0) uses only `req_addr[5:0]` and ignores bits 7:6. An extended access to an address from 0x00 to 0x3F reaches the same register as the immediate access to that address.
- R9: An extended access to 0x2F changes no register. Its read returns 0x00, and it does not raise `err_imm_escape`.
- R10: An immediate access to 0x2F changes no register and reads 0x00. It raises `err_imm_escape` for exactly the following cycle. No other access raises that flag.
- R11: Reads of unimplemented addresses return 0x00, and writes to them change nothing. This covers every extended address from 0x40 to 0xFF, and every low address that is not listed in the register map.
- R12: At every rising edge, each bit set in `evt_in` is ORed into the event latch at 0x14. A read of 0x14 returns the latch value from before that edge and empties the latch, except for the bits that `evt_in` sets in the same cycle. Writes to 0x14 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ext | input | 1 | 1 = extended-mode access (8-bit address) |
| req_addr | input | 8 | Register address; only bits 5:0 are used when `req_ext`=0 |
| req_wdata | input | 8 | Write data |
| evt_in | input | 8 | Event pulses ORed into the event latch |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | `rd_data` holds the answer to the previous cycle's read |
| err_imm_escape | output | 1 | The previous cycle carried an immediate access to 0x2F |

## Verification
The checker watches several behaviours on every cycle. It confirms the one-cycle timing of `rd_valid` and that `rd_data` is 0x00 while `rd_valid` is low. It confirms that the escape error flag follows immediate escape accesses and nothing else, and that neither form of escape access moves any control register. It also checks that an extended read beyond 0x3F returns zero, and that reading the event latch with no new events leaves it empty. Other behaviours need the bench's reference model to show: the overwrite, set and clear arithmetic of each alias, the exact byte order of the identification registers, the mirroring of immediate addresses into the extended space, and how a read of the latch behaves when an event arrives in the same cycle.

// File: rtl/ulpi_rb_pkg.sv
package ulpi_rb_pkg;
   localparam int DATA_W    = 8;
   localparam int ADDR_W    = 8;
   localparam int IMM_W     = 6;
   localparam int NUM_CTRL  = 4;

   typedef logic [DATA_W-1:0] rb_byte_t;

   typedef enum logic [1:0] {
      CTL_OVERWRITE = 2'd0,
      CTL_OR_IN     = 2'd1,
      CTL_MASK_OUT  = 2'd2
   } ctl_op_e;

   localparam logic [ADDR_W-1:0] ESCAPE_ADDR = 8'h2F;
   localparam logic [ADDR_W-1:0] EVT_ADDR    = 8'h14;
   localparam logic [ADDR_W-1:0] ID_LAST     = 8'h03;

   localparam logic [ADDR_W-1:0] CTRL_BASE [NUM_CTRL] = '{8'h04, 8'h07, 8'h0A, 8'h16};
   localparam logic [DATA_W-1:0] CTRL_INIT [NUM_CTRL] = '{8'h41, 8'h00, 8'h06, 8'h00};
endpackage

// File: rtl/ulpi_rb_decode.sv
module ulpi_rb_decode
   import ulpi_rb_pkg::*;
#(
   parameter int N_CTRL = NUM_CTRL
) (
   input  logic              ext,
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] eff_addr,
   output logic              is_escape,
   output logic              imm_escape,
   output logic [N_CTRL-1:0] ctrl_hit,
   output ctl_op_e           ctrl_op,
   output logic              id_hit,
   output logic              evt_hit
);
   localparam int PAD_W = ADDR_W - IMM_W;

   logic [N_CTRL-1:0] hit_wr, hit_set, hit_clr;

   assign eff_addr   = ext ? addr : {{PAD_W{1'b0}}, addr[IMM_W-1:0]};
   assign is_escape  = (eff_addr == ESCAPE_ADDR);
   assign imm_escape = is_escape && !ext;
   assign id_hit     = (eff_addr <= ID_LAST);
   assign evt_hit    = (eff_addr == EVT_ADDR);

   for (genvar i = 0; i < N_CTRL; i++) begin : g_cmp
      assign hit_wr[i]   = (eff_addr == CTRL_BASE[i]);
      assign hit_set[i]  = (eff_addr == CTRL_BASE[i] + 8'd1);
      assign hit_clr[i]  = (eff_addr == CTRL_BASE[i] + 8'd2);
      assign ctrl_hit[i] = hit_wr[i] | hit_set[i] | hit_clr[i];
   end

   always_comb begin
      ctrl_op = CTL_OVERWRITE;
      if (|hit_set)      ctrl_op = CTL_OR_IN;
      else if (|hit_clr) ctrl_op = CTL_MASK_OUT;
   end
endmodule

// File: rtl/ulpi_rb_ctrl_reg.sv
module ulpi_rb_ctrl_reg
   import ulpi_rb_pkg::*;
#(
   parameter int                W    = DATA_W,
   parameter logic [W-1:0]      INIT = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         wr_en,
   input  ctl_op_e      op,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         q <= INIT;
      end else if (wr_en) begin
         case (op)
            CTL_OR_IN:    q <= q | wdata;
            CTL_MASK_OUT: q <= q & ~wdata;
            default:      q <= wdata;
         endcase
      end
   end
endmodule

// File: rtl/ulpi_rb_evt_latch.sv
module ulpi_rb_evt_latch #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         rd_en,
   input  logic [W-1:0] evt,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst)        q <= '0;
      else if (rd_en) q <= evt;
      else            q <= q | evt;
   end
endmodule

// File: rtl/ulpi_phy_regbank.sv
module ulpi_phy_regbank
   import ulpi_rb_pkg::*;
#(
   parameter logic [15:0] VENDOR_ID  = 16'h1A2B,
   parameter logic [15:0] PRODUCT_ID = 16'h3C4D
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_ext,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] evt_in,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              err_imm_escape
);
   if (IMM_W >= ADDR_W) begin : g_bad_widths
      $error("immediate address must be narrower than extended address");
   end
   if (DATA_W != 8) begin : g_bad_data
      $error("register bank expects byte-wide registers");
   end

   logic [ADDR_W-1:0]          eff_addr;
   logic                       is_escape, imm_escape, id_hit, evt_hit;
   logic [NUM_CTRL-1:0]        ctrl_hit;
   ctl_op_e                    ctrl_op;
   logic [DATA_W-1:0]          ctrl_q [NUM_CTRL];
   logic [NUM_CTRL*DATA_W-1:0] ctrl_flat;
   logic [DATA_W-1:0]          evt_q;
   logic [DATA_W-1:0]          rd_mux;
   logic                       is_read, is_wr;

   assign is_read = req_valid && !req_write;
   assign is_wr   = req_valid &&  req_write;

   ulpi_rb_decode #(.N_CTRL(NUM_CTRL)) u_dec (
      .ext        (req_ext),
      .addr       (req_addr),
      .eff_addr   (eff_addr),
      .is_escape  (is_escape),
      .imm_escape (imm_escape),
      .ctrl_hit   (ctrl_hit),
      .ctrl_op    (ctrl_op),
      .id_hit     (id_hit),
      .evt_hit    (evt_hit)
   );

   for (genvar i = 0; i < NUM_CTRL; i++) begin : g_ctrl
      ulpi_rb_ctrl_reg #(.W(DATA_W), .INIT(CTRL_INIT[i])) u_reg (
         .clk   (clk),
         .rst   (rst),
         .wr_en (is_wr && ctrl_hit[i] && !is_escape),
         .op    (ctrl_op),
         .wdata (req_wdata),
         .q     (ctrl_q[i])
      );
      assign ctrl_flat[i*DATA_W +: DATA_W] = ctrl_q[i];
   end

   ulpi_rb_evt_latch #(.W(DATA_W)) u_evt (
      .clk   (clk),
      .rst   (rst),
      .rd_en (is_read && evt_hit),
      .evt   (evt_in),
      .q     (evt_q)
   );

   always_comb begin
      rd_mux = '0;
      if (id_hit) begin
         case (eff_addr[1:0])
            2'd0:    rd_mux = VENDOR_ID[7:0];
            2'd1:    rd_mux = VENDOR_ID[15:8];
            2'd2:    rd_mux = PRODUCT_ID[7:0];
            default: rd_mux = PRODUCT_ID[15:8];
         endcase
      end else if (evt_hit) begin
         rd_mux = evt_q;
      end else begin
         for (int i = 0; i < NUM_CTRL; i++)
            if (ctrl_hit[i]) rd_mux = ctrl_q[i];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_data        <= '0;
         rd_valid       <= 1'b0;
         err_imm_escape <= 1'b0;
      end else begin
         rd_valid       <= is_read;
         rd_data        <= is_read ? rd_mux : '0;
         err_imm_escape <= req_valid && imm_escape;
      end
   end
endmodule

// File: rtl/ulpi_rb_checker.sv
module ulpi_rb_checker (
   input logic        clk,
   input logic        rst,
   input logic        req_valid,
   input logic        req_write,
   input logic        req_ext,
   input logic [7:0]  req_addr,
   input logic [7:0]  evt_in,
   input logic [7:0]  rd_data,
   input logic        rd_valid,
   input logic        err_imm_escape,
   input logic [31:0] ctrl_flat,
   input logic [7:0]  evt_q
);
   logic rd_req, esc_imm, esc_ext, latch_rd, high_ext_rd;
   assign rd_req      = req_valid && !req_write;
   assign esc_imm     = req_valid && !req_ext && (req_addr[5:0] == 6'h2F);
   assign esc_ext     = req_valid &&  req_ext && (req_addr == 8'h2F);
   assign latch_rd    = rd_req && (req_addr[5:0] == 6'h14) && (!req_ext || req_addr[7:6] == 2'b00);
   assign high_ext_rd = rd_req && req_ext && (req_addr[7:6] != 2'b00);

   a_r2_valid_follows_read: assert property (@(posedge clk) disable iff (rst)
      rd_req |=> rd_valid);
   a_r2_no_valid_without_read: assert property (@(posedge clk) disable iff (rst)
      !rd_req |=> !rd_valid);
   a_r2_zero_when_idle: assert property (@(posedge clk) disable iff (rst)
      !rd_valid |-> (rd_data == 8'h00));
   a_r10_err_on_imm_escape: assert property (@(posedge clk) disable iff (rst)
      esc_imm |=> err_imm_escape);
   a_r10_err_only_escape: assert property (@(posedge clk) disable iff (rst)
      !esc_imm |=> !err_imm_escape);
   a_r10_imm_escape_no_change: assert property (@(posedge clk) disable iff (rst)
      esc_imm |=> $stable(ctrl_flat));
   a_r9_ext_escape_no_change: assert property (@(posedge clk) disable iff (rst)
      esc_ext |=> ($stable(ctrl_flat) && !err_imm_escape));
   a_r11_high_ext_reads_zero: assert property (@(posedge clk) disable iff (rst)
      high_ext_rd |=> (rd_data == 8'h00));
   a_r12_read_empties_latch: assert property (@(posedge clk) disable iff (rst)
      (latch_rd && evt_in == 8'h00) |=> (evt_q == 8'h00));
endmodule

bind ulpi_phy_regbank ulpi_rb_checker u_chk (
   .clk            (clk),
   .rst            (rst),
   .req_valid      (req_valid),
   .req_write      (req_write),
   .req_ext        (req_ext),
   .req_addr       (req_addr),
   .evt_in         (evt_in),
   .rd_data        (rd_data),
   .rd_valid       (rd_valid),
   .err_imm_escape (err_imm_escape),
   .ctrl_flat      (ctrl_flat),
   .evt_q          (evt_q)
);

// File: tb/tb_ulpi_phy_regbank.sv
module tb_ulpi_phy_regbank;
   localparam logic [15:0] VID = 16'h1A2B;
   localparam logic [15:0] PID = 16'h3C4D;
   localparam time HALF = 10ns;

   logic       clk = 1'b0;
   logic       rst, req_valid, req_write, req_ext;
   logic [7:0] req_addr, req_wdata, evt_in, rd_data;
   logic       rd_valid, err_imm_escape;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [7:0] m_ctrl [4];
   logic [7:0] m_evt;
   logic [7:0] bases [4] = '{8'h04, 8'h07, 8'h0A, 8'h16};
   logic [7:0] inits [4] = '{8'h41, 8'h00, 8'h06, 8'h00};

   always #(HALF) clk = ~clk;

   ulpi_phy_regbank #(.VENDOR_ID(VID), .PRODUCT_ID(PID)) dut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
      .req_ext(req_ext), .req_addr(req_addr), .req_wdata(req_wdata),
      .evt_in(evt_in), .rd_data(rd_data), .rd_valid(rd_valid),
      .err_imm_escape(err_imm_escape)
   );

   function automatic logic [7:0] eff(input logic ext, input logic [7:0] a);
      return ext ? a : {2'b00, a[5:0]};
   endfunction

   function automatic int ctrl_idx(input logic [7:0] e);
      for (int i = 0; i < 4; i++)
         if (e >= bases[i] && e <= bases[i] + 8'd2) return i;
      return -1;
   endfunction

   function automatic logic [7:0] exp_read(input logic [7:0] e);
      int k;
      if (e == 8'h00) return VID[7:0];
      if (e == 8'h01) return VID[15:8];
      if (e == 8'h02) return PID[7:0];
      if (e == 8'h03) return PID[15:8];
      if (e == 8'h14) return m_evt;
      k = ctrl_idx(e);
      if (k >= 0) return m_ctrl[k];
      return 8'h00;
   endfunction

   function automatic string tag_of(input logic ext, input logic [7:0] e);
      if (e == 8'h2F)      return ext ? "R9" : "R10";
      if (e >= 8'h40)      return "R11";
      if (e <= 8'h03)      return "R3";
      if (e == 8'h14)      return "R12";
      if (ctrl_idx(e) >= 0) return ext ? "R8" : "R7";
      return "R11";
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Caller is at a falling edge; result checked at the next falling edge.
   task automatic access(input logic wr, input logic ext, input logic [7:0] a,
                         input logic [7:0] d, input logic [7:0] ev);
      logic [7:0] e, exp;
      int k;
      e = eff(ext, a);
      exp = exp_read(e);
      req_valid = 1'b1; req_write = wr; req_ext = ext;
      req_addr = a; req_wdata = d; evt_in = ev;
      @(negedge clk);
      check("R2 rd_valid", {7'd0, rd_valid}, {7'd0, !wr});
      check(wr ? "R2 idle data" : tag_of(ext, e), rd_data, wr ? 8'h00 : exp);
      check((!ext && e == 8'h2F) ? "R10 err" : "R9 err", {7'd0, err_imm_escape},
            {7'd0, (!ext && e == 8'h2F)});
      // model update
      k = ctrl_idx(e);
      if (wr && k >= 0) begin
         if (e == bases[k])              m_ctrl[k] = d;
         else if (e == bases[k] + 8'd1)  m_ctrl[k] = m_ctrl[k] | d;
         else                            m_ctrl[k] = m_ctrl[k] & ~d;
      end
      if (!wr && e == 8'h14) m_evt = ev;
      else                   m_evt = m_evt | ev;
      req_valid = 1'b0; evt_in = 8'h00;
   endtask

   task automatic rd(input logic ext, input logic [7:0] a);
      access(1'b0, ext, a, 8'h00, 8'h00);
   endtask

   initial begin
      #(HALF * 2 * 200000);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] a;
      void'($urandom(32'd5150));
      rst = 1'b1; req_valid = 0; req_write = 0; req_ext = 0;
      req_addr = 0; req_wdata = 0; evt_in = 0;
      for (int i = 0; i < 4; i++) m_ctrl[i] = inits[i];
      m_evt = 8'h00;
      repeat (3) @(negedge clk);
      // R1: reset outputs
      check("R1 rd_valid", {7'd0, rd_valid}, 8'h00);
      check("R1 rd_data", rd_data, 8'h00);
      check("R1 err", {7'd0, err_imm_escape}, 8'h00);
      rst = 1'b0;
      // R1: reset values of the control registers and latch
      for (int i = 0; i < 4; i++) rd(1'b0, bases[i]);
      rd(1'b0, 8'h14);
      // R3: identification bytes; writes ignored
      for (int i = 0; i < 4; i++) rd(1'b0, i[7:0]);
      access(1'b1, 1'b0, 8'h01, 8'hFF, 8'h00);
      rd(1'b1, 8'h01);
      // R4/R5/R6 on the scratch register, R7 reads via aliases
      access(1'b1, 1'b0, 8'h16, 8'hA5, 8'h00);
      rd(1'b0, 8'h17);
      access(1'b1, 1'b0, 8'h17, 8'h18, 8'h00);
      rd(1'b0, 8'h18);
      access(1'b1, 1'b0, 8'h18, 8'h81, 8'h00);
      rd(1'b0, 8'h16);
      // R8: upper bits ignored in immediate mode; extended mirror
      access(1'b1, 1'b0, 8'hC7, 8'h3C, 8'h00);
      rd(1'b1, 8'h07);
      // R9 / R10 escapes
      access(1'b1, 1'b1, 8'h2F, 8'hFF, 8'h00);
      rd(1'b1, 8'h2F);
      access(1'b1, 1'b0, 8'h6F, 8'hFF, 8'h00);
      rd(1'b0, 8'h2F);
      for (int i = 0; i < 4; i++) rd(1'b0, bases[i]);
      // R11: unimplemented
      access(1'b1, 1'b1, 8'h84, 8'h55, 8'h00);
      rd(1'b1, 8'h84);
      rd(1'b0, 8'h04);
      rd(1'b0, 8'h20);
      // R12: latch, clear on read, same-cycle event survives
      access(1'b0, 1'b0, 8'h00, 8'h00, 8'h21);
      access(1'b1, 1'b0, 8'h14, 8'hFF, 8'h00);
      access(1'b0, 1'b0, 8'h14, 8'h00, 8'h40);
      rd(1'b0, 8'h14);
      rd(1'b0, 8'h14);
      // random mix
      for (int n = 0; n < 400; n++) begin
         case ($urandom_range(0, 3))
            0:       a = 8'($urandom_range(0, 8'h1A));
            1:       a = ($urandom_range(0, 1) != 0) ? 8'h2F : 8'h14;
            2:       a = 8'($urandom_range(0, 255));
            default: a = bases[$urandom_range(0, 3)] + 8'($urandom_range(0, 2));
         endcase
         access(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a,
                8'($urandom_range(0, 255)),
                ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 255)) : 8'h00);
      end
      done = 1;
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end
endmodule